// File: doc/BRIEF.md
# Two-argument arctangent front end: special values and octant reduction

This block sits ahead of an arctangent kernel in a single-precision floating-point unit. It takes the two operands of atan2(y, x) and classifies each one as NaN, infinite, zero or ordinary finite. Subnormals count as ordinary nonzero values. When the pair falls into one of the IEEE corner cases, the block produces the final result word itself. That word is either a quieted copy of the offending NaN or one of the constants 0, pi/4, pi/2, 3*pi/4 and pi, with its sign taken from y.

For every other pair, the block decides how the downstream divider and kernel should arrange the problem. It raises a swap flag when the kernel must evaluate atan(x/y) rather than atan(y/x), which keeps the kernel's argument at magnitude one or less. It also chooses the constant to add (none, pi/2 or pi), the sign of that constant, and whether the kernel term is subtracted. The offset is always large next to the bounded kernel term, so the final add or subtract never cancels significant bits.

An operand pair is accepted on any cycle with `inValid` high. The answer appears on the registered outputs one cycle later, marked by `outValid`. `outSpecial` tells the consumer which half of the output is meaningful for that cycle.

Top module: `atan2_octant_prep`

## Requirements
- R1: `outValid` is high exactly in the cycles that follow a cycle with `inValid` high. Reset clears `outValid` and every other output to zero.
- R2: NaN checks come first, and x is tested before y. If x is NaN the result is x; otherwise, if y is NaN, the result is y. In both cases the payload and sign are kept and the quiet bit (bit 22) is forced to one.
- R3: If x is +infinity, the result is pi/4 when y is infinite and zero otherwise. In both cases the sign bit (bit 31) is copied from y.
- R4: If x is -infinity, the result is 3*pi/4 when y is infinite and pi otherwise. In both cases the sign is copied from y.
- R5: If x is not infinite and y is infinite, the result is pi/2 with the sign of y. This applies even when x is a zero.
- R6: If x is +0 or -0 and y is finite and nonzero, the result is pi/2 with the sign of y. A subnormal y counts as nonzero.
- R7: If y is a zero and the cases above do not apply, the result is a zero with the sign of y when x has sign bit 0, and pi with the sign of y when x has sign bit 1. This holds for x = +0 and x = -0 as well.
- R8: `outSpecial` is 1 exactly when R2 to R7 decide the result. While it is 1, all reduction outputs are 0. While it is 0, `outResult` is 0.
- R9: On the general path, when bits [30:0] of y are greater than bits [30:0] of x (compared as unsigned integers), the block sets `outSwap`=1 and `outTermNeg`=1. It sets `outOffsetSel`=1 (pi/2) and gives `outOffsetNeg` the sign of y.
- R10: On the general path, when |y| is at most |x| (ties included) and x is positive, the block sets `outSwap`=0 and `outOffsetSel`=0 (no offset). It also sets `outOffsetNeg`=0 and `outTermNeg`=0.
- R11: On the general path, when |y| is at most |x| and x is negative, the block sets `outSwap`=0 and `outOffsetSel`=2 (pi). It gives `outOffsetNeg` the sign of y and sets `outTermNeg`=0.
- R12: The constants are pi/4 = 0x3F490FDB, pi/2 = 0x3FC90FDB, 3*pi/4 = 0x4016CBE4 and pi = 0x40490FDB. A negative result differs from these only in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair present this cycle |
| inY | input | 32 | Operand y (numerator), FP32 |
| inX | input | 32 | Operand x (denominator), FP32 |
| outValid | output | 1 | Registered outputs hold a result |
| outSpecial | output | 1 | outResult is the final atan2 value |
| outResult | output | 32 | Final FP32 word for special cases, zero otherwise |
| outSwap | output | 1 | Kernel evaluates atan(x/y) instead of atan(y/x) |
| outOffsetSel | output | 2 | 0 no offset, 1 pi/2, 2 pi |
| outOffsetNeg | output | 1 | Offset constant is negated |
| outTermNeg | output | 1 | Kernel term is subtracted from the offset |

## Verification
A classifier or priority fault inside this block shows up at the ports one cycle after the operand pair that triggers it. It appears either as a wrong constant or sign on `outResult`, or as `outSpecial` disagreeing with the class of the pair. A faulty magnitude comparison or octant decision shows up on the same cycle as a wrong swap, offset or term-sign combination. No state carries over between pairs, so each fault appears only on the pairs that exercise it. The stimulus therefore walks every branch of the special-value priority chain, including signed-zero pairs, magnitude ties and subnormals, and then streams mixed pairs back to back with gaps in between.

// File: rtl/atan2_pkg.sv
`timescale 1ns/1ps
package atan2_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int MAG_W  = WORD_W - 1;
  localparam int QUIET_BIT = MAN_W - 1;

  localparam logic [WORD_W-1:0] K_QUARTER_PI = 32'h3F490FDB;
  localparam logic [WORD_W-1:0] K_HALF_PI    = 32'h3FC90FDB;
  localparam logic [WORD_W-1:0] K_3Q_PI      = 32'h4016CBE4;
  localparam logic [WORD_W-1:0] K_PI         = 32'h40490FDB;

  typedef enum logic [2:0] {
    RK_ZERO, RK_QPI, RK_HPI, RK_3QPI, RK_PI, RK_NAN_X, RK_NAN_Y
  } resKind_e;

  typedef enum logic [1:0] {
    OFS_NONE = 2'd0, OFS_HALF_PI = 2'd1, OFS_PI = 2'd2
  } offSel_e;

  typedef struct packed {
    logic isNan;
    logic isInf;
    logic isZero;
    logic sign;
  } fpClass_t;

  typedef struct packed {
    logic     load;
    logic     special;
    resKind_e kind;
    logic     resSign;
    logic     swap;
    offSel_e  offSel;
    logic     offNeg;
    logic     termNeg;
  } ctrlStrobe_t;
endpackage

// File: rtl/atan2_classify.sv
`timescale 1ns/1ps
module atan2_classify
  import atan2_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] word,
  output fpClass_t       cls
);
  logic [EW-1:0] expField;
  logic [MW-1:0] manField;
  logic expAllOnes;
  logic expAllZero;
  logic manZero;

  assign expField   = word[EW+MW-1:MW];
  assign manField   = word[MW-1:0];
  assign expAllOnes = &expField;
  assign expAllZero = ~|expField;
  assign manZero    = ~|manField;

  always_comb begin
    cls.isNan  = expAllOnes & ~manZero;
    cls.isInf  = expAllOnes & manZero;
    cls.isZero = expAllZero & manZero;
    cls.sign   = word[EW+MW];
  end
endmodule

// File: rtl/atan2_ctrl.sv
`timescale 1ns/1ps
module atan2_ctrl
  import atan2_pkg::*;
(
  input  logic        inValid,
  input  fpClass_t    clsY,
  input  fpClass_t    clsX,
  input  logic        yGtX,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe         = '0;
    strobe.kind    = RK_ZERO;
    strobe.offSel  = OFS_NONE;
    strobe.load    = inValid;
    strobe.resSign = clsY.sign;
    if (clsX.isNan) begin
      strobe.special = 1'b1;
      strobe.kind    = RK_NAN_X;
    end else if (clsY.isNan) begin
      strobe.special = 1'b1;
      strobe.kind    = RK_NAN_Y;
    end else if (clsX.isInf && !clsX.sign) begin
      strobe.special = 1'b1;
      strobe.kind    = clsY.isInf ? RK_QPI : RK_ZERO;
    end else if (clsX.isInf) begin
      strobe.special = 1'b1;
      strobe.kind    = clsY.isInf ? RK_3QPI : RK_PI;
    end else if (clsY.isInf) begin
      strobe.special = 1'b1;
      strobe.kind    = RK_HPI;
    end else if (clsX.isZero && !clsY.isZero) begin
      strobe.special = 1'b1;
      strobe.kind    = RK_HPI;
    end else if (clsY.isZero) begin
      strobe.special = 1'b1;
      strobe.kind    = clsX.sign ? RK_PI : RK_ZERO;
    end else if (yGtX) begin
      strobe.swap    = 1'b1;
      strobe.offSel  = OFS_HALF_PI;
      strobe.offNeg  = clsY.sign;
      strobe.termNeg = 1'b1;
    end else if (!clsX.sign) begin
      strobe.offSel  = OFS_NONE;
    end else begin
      strobe.offSel  = OFS_PI;
      strobe.offNeg  = clsY.sign;
    end
  end
endmodule

// File: rtl/atan2_dp.sv
`timescale 1ns/1ps
module atan2_dp
  import atan2_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inY,
  input  logic [WORD_W-1:0] inX,
  input  ctrlStrobe_t       strobe,
  output logic              yGtX,
  output logic              outValid,
  output logic              outSpecial,
  output logic [WORD_W-1:0] outResult,
  output logic              outSwap,
  output logic [1:0]        outOffsetSel,
  output logic              outOffsetNeg,
  output logic              outTermNeg
);
  localparam logic [WORD_W-1:0] QUIET_MASK = WORD_W'(1) << QUIET_BIT;

  logic [MAG_W-1:0]  magY;
  logic [MAG_W-1:0]  magX;
  logic [WORD_W-1:0] constWord;
  logic [WORD_W-1:0] nextWord;

  assign magY = inY[MAG_W-1:0];
  assign magX = inX[MAG_W-1:0];
  assign yGtX = magY > magX;

  always_comb begin
    unique case (strobe.kind)
      RK_QPI:  constWord = K_QUARTER_PI;
      RK_HPI:  constWord = K_HALF_PI;
      RK_3QPI: constWord = K_3Q_PI;
      RK_PI:   constWord = K_PI;
      default: constWord = '0;
    endcase
    if (strobe.kind == RK_NAN_X)      nextWord = inX | QUIET_MASK;
    else if (strobe.kind == RK_NAN_Y) nextWord = inY | QUIET_MASK;
    else                              nextWord = {strobe.resSign, constWord[MAG_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outSpecial   <= 1'b0;
      outResult    <= '0;
      outSwap      <= 1'b0;
      outOffsetSel <= 2'd0;
      outOffsetNeg <= 1'b0;
      outTermNeg   <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outSpecial   <= strobe.special;
        outResult    <= strobe.special ? nextWord : '0;
        outSwap      <= strobe.swap;
        outOffsetSel <= strobe.offSel;
        outOffsetNeg <= strobe.offNeg;
        outTermNeg   <= strobe.termNeg;
      end
    end
  end
endmodule

// File: rtl/atan2_octant_prep.sv
`timescale 1ns/1ps
module atan2_octant_prep
  import atan2_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inY,
  input  logic [WORD_W-1:0] inX,
  output logic              outValid,
  output logic              outSpecial,
  output logic [WORD_W-1:0] outResult,
  output logic              outSwap,
  output logic [1:0]        outOffsetSel,
  output logic              outOffsetNeg,
  output logic              outTermNeg
);
  localparam int N_OPS = 2;

  logic [WORD_W-1:0] opWord [N_OPS];
  fpClass_t          opCls  [N_OPS];
  ctrlStrobe_t       strobe;
  logic              yGtX;

  assign opWord[0] = inY;
  assign opWord[1] = inX;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    atan2_classify #(.EW(EXP_W), .MW(MAN_W)) i_cls (
      .word (opWord[g]),
      .cls  (opCls[g])
    );
  end

  atan2_ctrl i_ctrl (
    .inValid (inValid),
    .clsY    (opCls[0]),
    .clsX    (opCls[1]),
    .yGtX    (yGtX),
    .strobe  (strobe)
  );

  atan2_dp i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .inY          (inY),
    .inX          (inX),
    .strobe       (strobe),
    .yGtX         (yGtX),
    .outValid     (outValid),
    .outSpecial   (outSpecial),
    .outResult    (outResult),
    .outSwap      (outSwap),
    .outOffsetSel (outOffsetSel),
    .outOffsetNeg (outOffsetNeg),
    .outTermNeg   (outTermNeg)
  );
endmodule

// File: rtl/atan2_checks.sv
`timescale 1ns/1ps
module atan2_checks (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] inY,
  input logic [31:0] inX,
  input logic        outValid,
  input logic        outSpecial,
  input logic [31:0] outResult,
  input logic        outSwap,
  input logic [1:0]  outOffsetSel,
  input logic        outOffsetNeg,
  input logic        outTermNeg
);
  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_nan_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSpecial && (&outResult[30:23]) && (|outResult[22:0])) |-> outResult[22]);
  // Non-NaN special results carry the sign of y (R3 to R7 share this)
  assert_const_sign_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSpecial && !(&outResult[30:23])) |-> outResult[31] == $past(inY[31]));
  assert_general_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSpecial) |-> outResult == 32'd0);
  assert_special_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSpecial) |-> (!outSwap && !outTermNeg && outOffsetSel == 2'd0 && !outOffsetNeg));
  assert_swap_choice_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSpecial) |-> outSwap == ($past(inY[30:0]) > $past(inX[30:0])));
  assert_swap_offset_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSpecial && outSwap) |->
      (outTermNeg && outOffsetSel == 2'd1 && outOffsetNeg == $past(inY[31])));
  assert_xpos_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSpecial && !outSwap && !$past(inX[31])) |->
      (outOffsetSel == 2'd0 && !outOffsetNeg && !outTermNeg));
  assert_xneg_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSpecial && !outSwap && $past(inX[31])) |->
      (outOffsetSel == 2'd2 && outOffsetNeg == $past(inY[31]) && !outTermNeg));
endmodule

bind atan2_octant_prep atan2_checks i_checks (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .inY          (inY),
  .inX          (inX),
  .outValid     (outValid),
  .outSpecial   (outSpecial),
  .outResult    (outResult),
  .outSwap      (outSwap),
  .outOffsetSel (outOffsetSel),
  .outOffsetNeg (outOffsetNeg),
  .outTermNeg   (outTermNeg)
);

// File: tb/test_atan2_octant_prep.sv
`timescale 1ns/1ps
module test_atan2_octant_prep;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inY = '0;
  logic [31:0] inX = '0;
  logic        outValid, outSpecial, outSwap, outOffsetNeg, outTermNeg;
  logic [31:0] outResult;
  logic [1:0]  outOffsetSel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // expected vector: special, word, swap, sel, offNeg, termNeg
  logic [37:0] pendExp = '0;
  bit          pendValid = 0;
  string       pendTag = "R1";

  always #10 clk = ~clk;

  atan2_octant_prep i_atan2_octant_prep (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inY(inY), .inX(inX),
    .outValid(outValid), .outSpecial(outSpecial), .outResult(outResult),
    .outSwap(outSwap), .outOffsetSel(outOffsetSel),
    .outOffsetNeg(outOffsetNeg), .outTermNeg(outTermNeg)
  );

  function automatic bit isNan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction
  function automatic bit isInf(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] == 0);
  endfunction
  function automatic bit isZero(input logic [31:0] w);
    return w[30:0] == 0;
  endfunction

  function automatic void refModel(input logic [31:0] y, input logic [31:0] x,
                                   output logic [37:0] e, output string tag);
    logic [31:0] w;
    logic sy;
    sy = y[31];
    w = 32'd0;
    e = '0;
    if (isNan(x)) begin
      tag = "R2"; e = {1'b1, x | 32'h0040_0000, 5'b0};
    end else if (isNan(y)) begin
      tag = "R2"; e = {1'b1, y | 32'h0040_0000, 5'b0};
    end else begin
      tag = "";
      if (isInf(x) && !x[31]) begin
        tag = "R3 R12"; w = isInf(y) ? 32'h3F490FDB : 32'h0;
      end else if (isInf(x)) begin
        tag = "R4 R12"; w = isInf(y) ? 32'h4016CBE4 : 32'h40490FDB;
      end else if (isInf(y)) begin
        tag = "R5 R12"; w = 32'h3FC90FDB;
      end else if (isZero(x) && !isZero(y)) begin
        tag = "R6 R12"; w = 32'h3FC90FDB;
      end else if (isZero(y)) begin
        tag = "R7 R12"; w = x[31] ? 32'h40490FDB : 32'h0;
      end
      if (tag != "") begin
        w[31] = sy;
        e = {1'b1, w, 5'b0};
      end else if (y[30:0] > x[30:0]) begin
        tag = "R9 R8"; e = {1'b0, 32'h0, 1'b1, 2'd1, sy, 1'b1};
      end else if (!x[31]) begin
        tag = "R10 R8"; e = {1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0};
      end else begin
        tag = "R11 R8"; e = {1'b0, 32'h0, 1'b0, 2'd2, sy, 1'b0};
      end
    end
  endfunction

  task automatic checkOutputs();
    logic [37:0] act;
    total++;
    if (outValid !== pendValid) begin
      bad++;
      $display("FAIL R1 outValid actual=%0b expected=%0b", outValid, pendValid);
    end
    if (pendValid) begin
      act = {outSpecial, outResult, outSwap, outOffsetSel, outOffsetNeg, outTermNeg};
      total++;
      if (act !== pendExp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", pendTag, act, pendExp);
      end
    end
  endtask

  task automatic step(input bit v, input logic [31:0] y, input logic [31:0] x);
    @(negedge clk);
    checkOutputs();
    inValid = v; inY = y; inX = x;
    pendValid = v;
    if (v) refModel(y, x, pendExp, pendTag);
  endtask

  function automatic logic [31:0] randWord();
    logic [31:0] w;
    int k;
    w = $urandom;
    k = $urandom_range(0, 7);
    if (k == 0) w[30:23] = 8'h00;
    else if (k == 1) w[30:23] = 8'hFF;
    if ($urandom_range(0, 5) == 0) w[22:0] = 23'd0;
    return w;
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (outValid !== 1'b0 || outResult !== 32'd0 || outSpecial !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset actual=%b/%h expected=0/0", outValid, outResult);
    end
    rstN = 1'b1;
    // R2 NaN priority and quieting
    step(1, 32'h3F800000, 32'h7FC00001);
    step(1, 32'h3F800000, 32'h7F800001);
    step(1, 32'hFFA00000, 32'hFFA00001);
    step(1, 32'h7F800005, 32'h3F800000);
    // R3 x = +inf
    step(1, 32'h7F800000, 32'h7F800000);
    step(1, 32'hFF800000, 32'h7F800000);
    step(1, 32'h40000000, 32'h7F800000);
    step(1, 32'hC0000000, 32'h7F800000);
    step(1, 32'h80000000, 32'h7F800000);
    // R4 x = -inf
    step(1, 32'h7F800000, 32'hFF800000);
    step(1, 32'hFF800000, 32'hFF800000);
    step(1, 32'h3F800000, 32'hFF800000);
    step(1, 32'h80000000, 32'hFF800000);
    // R5 y infinite
    step(1, 32'hFF800000, 32'h40A00000);
    step(1, 32'h7F800000, 32'h80000000);
    // R6 x zero
    step(1, 32'hC0400000, 32'h00000000);
    step(1, 32'h00000001, 32'h80000000);
    // R7 y zero
    step(1, 32'h00000000, 32'h3F800000);
    step(1, 32'h80000000, 32'h3F800000);
    step(1, 32'h00000000, 32'hBF800000);
    step(1, 32'h80000000, 32'h80000000);
    step(1, 32'h00000000, 32'h00000000);
    step(1, 32'h80000000, 32'h00000003);
    // bubble
    step(0, 32'h0, 32'h0);
    // R9 to R11 general path
    step(1, 32'h40000000, 32'h3F800000);
    step(1, 32'hC0000000, 32'h3F800000);
    step(1, 32'hC0000000, 32'hBF800000);
    step(1, 32'h3F800000, 32'h3F800000);
    step(1, 32'hBF800000, 32'hBF800000);
    step(1, 32'h3F800000, 32'hC0000000);
    step(1, 32'h00000002, 32'h80000005);
    step(1, 32'h00000009, 32'h00000005);
    step(0, 32'h0, 32'h0);
    step(0, 32'h0, 32'h0);
    // mixed stream
    for (int i = 0; i < 2000; i++) begin
      step(($urandom_range(0, 6) != 0), randWord(), randWord());
    end
    step(0, 32'h0, 32'h0);
    step(0, 32'h0, 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule